// File: doc/BRIEF.md
# Interrupt Router with 16-bit CPU Targets

The block takes software interrupts, per-CPU private interrupt lines and shared peripheral interrupt lines. Each source has its own pending state, enable, trigger mode, 8-bit priority and, for shared sources, a 16-bit mask that chooses which CPUs receive it. For every CPU the router presents the best pending, enabled source it may deliver. Software programs it through a word-addressed register port. Every access carries the number of the requesting CPU, so the banked per-CPU state of IDs 0–31 is selected by the requester.

Source IDs fall into three classes. IDs 0–15 are raised only by register writes and are always edge-like. IDs 16–31 come from a private line per CPU on `ppi_in`. IDs 32 and up come from `spi_in`, where bit `s` is ID `32+s`. A CPU handles a request by writing the ID back to the acknowledge register, which drops the pending state. The source count is a parameter: a multiple of 32 between 64 and 512, with at most 16 CPUs. At most 510 lines are served.

Top module: `irq_router`

## Requirements
- R1: After reset `irq_req` and `irq_id` are zero, the control register reads 0, every enable reads 0, every priority reads 0, every shared source is level-triggered (configuration bit 0) and every shared target mask is 0.
- R2: Bit 0 of the control register (word 0x000) is the global enable. In any cycle where it is 0, `irq_req` is all zero in the following cycle.
- R3: The type register (word 0x001) reads NUM_SRC/32−1 in bits [4:0]. Sources with ID ≥ 510 are never presented.
- R4: Word 0x020+id/32 is the enable-set bank and word 0x030+id/32 is the enable-clear bank, with bit id%32 in each. Writing 1 to a set bit enables that source and writing 1 to a clear bit disables it. Zero bits leave the state unchanged. Both banks read back the current enables.
- R5: Word 0 of both enable banks, and the pending state of IDs 0–31, are held per CPU. An access affects and returns only the copy of the CPU named on `reg_cpu`.
- R6: The target mask of ID `id` is in word 0x100+id/2: even IDs use bits [15:0] and odd IDs use bits [31:16]. Bit c of a shared source's mask routes that source to CPU c. Words 0x100–0x10F read as the requester's one-hot mask in both halves, and writes to them are ignored.
- R7: The trigger bit of ID `id` is word 0x040+id/32, bit id%32, where 1 means rising edge and 0 means level-high. Bits of IDs 0–15 always read 1 and writes to them are ignored.
- R8: For an edge source, a 0→1 transition of its line sets pending, and pending stays set after the line falls until the source is acknowledged.
- R9: For a level source, pending is set in every cycle its line is high, and an acknowledge in such a cycle has no effect. Once the line is low, pending holds until the source is acknowledged.
- R10: A write to word 0x002 sets SGI `wdata[3:0]` pending for every CPU c whose bit `wdata[8+c]` is 1, and for no other CPU.
- R11: A write to word 0x003 with an ID in the low bits clears that source's pending state. For IDs below 32 it clears only the requester's copy.
- R12: Priorities are bytes at word 0x200+id/4, byte id%4, and a lower value means more urgent. Each CPU's `irq_id` shows the most urgent pending, enabled, routed source, and on a tie the lowest ID wins. `irq_req`/`irq_id` are registered one cycle behind the pending and configuration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | CPUW | Number of the requesting CPU |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ppi_in | input | NUM_CPU*16 | Private lines; bit c*16+k is ID 16+k of CPU c |
| spi_in | input | NUM_SRC−32 | Shared lines; bit s is ID 32+s |
| irq_req | output | NUM_CPU | Request toward each CPU interface |
| irq_id | output | NUM_CPU*IDW | Winning ID per CPU, field c at c*IDW |

## Verification
The assertions check four behaviours on every cycle:
- a cleared global enable silences all requests on the next cycle;
- an SGI write leaves the chosen ID pending in the banked state of each targeted CPU;
- the private target words always read as one duplicated one-hot mask;
- the fixed SGI trigger bits read as ones.

Only the bench scenarios can show the following:
- the priority order and the lowest-ID tie break;
- a level source that survives an early acknowledge;
- an edge source latched after its pulse;
- routing by target mask;
- isolation between one CPU's private copies and another's.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int MAX_LINES = 510;
    localparam logic [9:0] A_CTRL  = 10'h000;
    localparam logic [9:0] A_TYPE  = 10'h001;
    localparam logic [9:0] A_SGI   = 10'h002;
    localparam logic [9:0] A_ACK   = 10'h003;
    localparam logic [9:0] A_ENSET = 10'h020;
    localparam logic [9:0] A_ENCLR = 10'h030;
    localparam logic [9:0] A_CFG   = 10'h040;
    localparam logic [9:0] A_TGT   = 10'h100;
    localparam logic [9:0] A_PRIO  = 10'h200;
endpackage

// File: rtl/irq_router_pend.sv
// Pending latches for a bank of sources: edge or level capture, software set, acknowledge clear.
module irq_router_pend #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] line_q;
    logic [W-1:0] hw_set;

    // Level sources set pending while high; edge sources only on a 0->1 step.
    assign hw_set = (edge_mode & line & ~line_q) | (~edge_mode & line);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            pend   <= '0;
        end else begin
            line_q <= line;
            pend   <= (pend & ~clr) | hw_set | sw_set;
        end
    end
endmodule

// File: rtl/irq_router_pick.sv
// Selects the most urgent eligible source: lowest priority value, then lowest ID.
module irq_router_pick #(
    parameter int N   = 64,
    parameter int IDW = 6
) (
    input  logic [N-1:0]      elig,
    input  logic [N-1:0][7:0] prio,
    output logic              found,
    output logic [IDW-1:0]    win_id
);
    logic [7:0] best;

    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best   = '1;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || prio[i] < best)) begin
                found  = 1'b1;
                best   = prio[i];
                win_id = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int NUM_CPU = 4,
    localparam int CPUW    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDW     = $clog2(NUM_SRC),
    localparam int NSPI    = NUM_SRC - 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [9:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic [CPUW-1:0]        reg_cpu,
    output logic [31:0]            reg_rdata,
    input  logic [NUM_CPU*16-1:0]  ppi_in,
    input  logic [NSPI-1:0]        spi_in,
    output logic [NUM_CPU-1:0]     irq_req,
    output logic [NUM_CPU*IDW-1:0] irq_id
);
    localparam int NWORD = NUM_SRC / 32;
    localparam int LINES = (NUM_SRC > MAX_LINES) ? MAX_LINES : NUM_SRC;

    logic                             ctrl_en;
    logic [NUM_CPU-1:0][31:0]         en_prv, pend_prv, sgi_set, prv_clr, prv_line;
    logic [NSPI-1:0]                  en_spi, pend_spi, spi_clr;
    logic [NUM_SRC-1:0]               cfg_q;
    logic [NSPI-1:0][15:0]            tgt_q;
    logic [NUM_SRC-1:0][7:0]          prio_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  elig;
    logic [NUM_CPU-1:0]               win_v;
    logic [NUM_CPU-1:0][IDW-1:0]      win_id;

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            en_prv  <= '0;
            en_spi  <= '0;
            cfg_q   <= {{NSPI{1'b0}}, 16'h0000, 16'hFFFF};
            tgt_q   <= '0;
            prio_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) ctrl_en <= reg_wdata[0];
            for (int c = 0; c < NUM_CPU; c++) begin
                if (CPUW'(c) == reg_cpu) begin
                    if (reg_addr == A_ENSET) en_prv[c] <= en_prv[c] | reg_wdata;
                    if (reg_addr == A_ENCLR) en_prv[c] <= en_prv[c] & ~reg_wdata;
                end
            end
            for (int w = 1; w < NWORD; w++) begin
                if (reg_addr == A_ENSET + 10'(w))
                    en_spi[(w-1)*32 +: 32] <= en_spi[(w-1)*32 +: 32] | reg_wdata;
                if (reg_addr == A_ENCLR + 10'(w))
                    en_spi[(w-1)*32 +: 32] <= en_spi[(w-1)*32 +: 32] & ~reg_wdata;
                if (reg_addr == A_CFG + 10'(w))
                    cfg_q[w*32 +: 32] <= reg_wdata;
            end
            // SGI trigger bits stay fixed; only the private half of word 0 is writable.
            if (reg_addr == A_CFG) cfg_q[31:16] <= reg_wdata[31:16];
            for (int s = 0; s < NSPI; s++) begin
                if (reg_addr == A_TGT + 10'((s + 32) / 2))
                    tgt_q[s] <= ((s % 2) == 1) ? reg_wdata[31:16] : reg_wdata[15:0];
            end
            for (int s = 0; s < NUM_SRC; s++) begin
                if (reg_addr == A_PRIO + 10'(s / 4))
                    prio_q[s] <= reg_wdata[(s % 4)*8 +: 8];
            end
        end
    end

    // ---------------- software set and acknowledge decode ----------------
    always_comb begin
        sgi_set = '0;
        prv_clr = '0;
        spi_clr = '0;
        if (reg_wr && reg_addr == A_SGI) begin
            for (int c = 0; c < NUM_CPU; c++)
                if (reg_wdata[8 + c]) sgi_set[c][reg_wdata[3:0]] = 1'b1;
        end
        if (reg_wr && reg_addr == A_ACK) begin
            for (int c = 0; c < NUM_CPU; c++)
                if (CPUW'(c) == reg_cpu && reg_wdata[IDW-1:5] == '0)
                    prv_clr[c][reg_wdata[4:0]] = 1'b1;
            for (int s = 0; s < NSPI; s++)
                if (reg_wdata[IDW-1:0] == IDW'(s + 32)) spi_clr[s] = 1'b1;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++)
            prv_line[c] = {ppi_in[c*16 +: 16], 16'h0000};
    end

    // ---------------- pending state ----------------
    for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_prv
        irq_router_pend #(.W(32)) u_pend (
            .clk       (clk),
            .rst_n     (rst_n),
            .line      (prv_line[gc]),
            .edge_mode (cfg_q[31:0]),
            .sw_set    (sgi_set[gc]),
            .clr       (prv_clr[gc]),
            .pend      (pend_prv[gc])
        );
    end

    irq_router_pend #(.W(NSPI)) u_spi_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (spi_in),
        .edge_mode (cfg_q[NUM_SRC-1:32]),
        .sw_set    ({NSPI{1'b0}}),
        .clr       (spi_clr),
        .pend      (pend_spi)
    );

    // ---------------- eligibility and selection ----------------
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < 32; i++)
                elig[c][i] = ctrl_en & en_prv[c][i] & pend_prv[c][i];
            for (int s = 0; s < NSPI; s++)
                elig[c][32 + s] = ctrl_en & en_spi[s] & pend_spi[s] & tgt_q[s][c]
                                  & ((s + 32) < LINES);
        end
    end

    for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_pick
        irq_router_pick #(.N(NUM_SRC), .IDW(IDW)) u_pick (
            .elig   (elig[gc]),
            .prio   (prio_q),
            .found  (win_v[gc]),
            .win_id (win_id[gc])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req <= '0;
            irq_id  <= '0;
        end else begin
            irq_req <= win_v;
            for (int c = 0; c < NUM_CPU; c++)
                irq_id[c*IDW +: IDW] <= win_id[c];
        end
    end

    // ---------------- register read ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) reg_rdata[0] = ctrl_en;
        if (reg_addr == A_TYPE) reg_rdata[4:0] = 5'(NWORD - 1);
        if (reg_addr == A_CFG)  reg_rdata = cfg_q[31:0];
        for (int c = 0; c < NUM_CPU; c++) begin
            if (CPUW'(c) == reg_cpu && (reg_addr == A_ENSET || reg_addr == A_ENCLR))
                reg_rdata = en_prv[c];
        end
        for (int w = 1; w < NWORD; w++) begin
            if (reg_addr == A_ENSET + 10'(w) || reg_addr == A_ENCLR + 10'(w))
                reg_rdata = en_spi[(w-1)*32 +: 32];
            if (reg_addr == A_CFG + 10'(w))
                reg_rdata = cfg_q[w*32 +: 32];
        end
        for (int w = 0; w < 16; w++) begin
            if (reg_addr == A_TGT + 10'(w))
                reg_rdata = {2{16'(1) << reg_cpu}};
        end
        for (int s = 0; s < NSPI; s++) begin
            if (reg_addr == A_TGT + 10'((s + 32) / 2))
                reg_rdata[(s % 2)*16 +: 16] = tgt_q[s];
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (reg_addr == A_PRIO + 10'(s / 4))
                reg_rdata[(s % 4)*8 +: 8] = prio_q[s];
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [9:0]               reg_addr,
    input logic [NUM_CPU-1:0]       sgi_mask,
    input logic [3:0]               sgi_num,
    input logic [31:0]              reg_rdata,
    input logic                     ctrl_en,
    input logic [NUM_CPU-1:0][31:0] pend_prv,
    input logic [NUM_CPU-1:0]       irq_req
);
    logic [3:0] sgi_num_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sgi_num_q <= '0;
        else        sgi_num_q <= sgi_num;
    end

    AST_GLOBAL_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (irq_req == '0)) else $error("global enable off but request seen"); // R2

    AST_PRIVATE_TARGET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[9:4] == A_TGT[9:4]) |-> ($onehot(reg_rdata[15:0]) && reg_rdata[31:16] == reg_rdata[15:0]))
        else $error("private target word not a duplicated one-hot mask"); // R6

    AST_SGI_TRIGGER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CFG) |-> (reg_rdata[15:0] == 16'hFFFF))
        else $error("SGI trigger bits changed"); // R7

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_sgi
        AST_SGI_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_SGI && sgi_mask[c]) |=> pend_prv[c][sgi_num_q])
            else $error("SGI write did not set pending"); // R10
    end
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .sgi_mask  (reg_wdata[8 +: NUM_CPU]),
    .sgi_num   (reg_wdata[3:0]),
    .reg_rdata (reg_rdata),
    .ctrl_en   (ctrl_en),
    .pend_prv  (pend_prv),
    .irq_req   (irq_req)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
    localparam int NUM_SRC = 64;
    localparam int NUM_CPU = 4;
    localparam int IDW     = 6;
    localparam int NSPI    = NUM_SRC - 32;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     reg_wr = 1'b0;
    logic [9:0]               reg_addr = '0;
    logic [31:0]              reg_wdata = '0;
    logic [1:0]               reg_cpu = '0;
    logic [31:0]              reg_rdata;
    logic [NUM_CPU*16-1:0]    ppi_in = '0;
    logic [NSPI-1:0]          spi_in = '0;
    logic [NUM_CPU-1:0]       irq_req;
    logic [NUM_CPU*IDW-1:0]   irq_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_router #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_cpu(reg_cpu), .reg_rdata(reg_rdata),
        .ppi_in(ppi_in), .spi_in(spi_in), .irq_req(irq_req), .irq_id(irq_id)
    );

    // Fields: [80] write, [79:78] cpu, [77:68] addr, [67:36] wdata, [35:4] expected read, [3:0] requirement
    localparam int NV = 24;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 2'd0, 10'h000, 32'h0,        32'h0,        4'd1 },  // R1 control off
        {1'b0, 2'd0, 10'h001, 32'h0,        32'h1,        4'd3 },  // R3 type = 64/32-1
        {1'b0, 2'd0, 10'h041, 32'h0,        32'h0,        4'd1 },  // R1 shared level
        {1'b0, 2'd0, 10'h021, 32'h0,        32'h0,        4'd1 },  // R1 enables clear
        {1'b0, 2'd0, 10'h040, 32'h0,        32'h0000FFFF, 4'd7 },  // R7 SGI bits fixed
        {1'b1, 2'd0, 10'h040, 32'h0,        32'h0,        4'd7 },
        {1'b0, 2'd0, 10'h040, 32'h0,        32'h0000FFFF, 4'd7 },  // R7 write ignored
        {1'b1, 2'd0, 10'h021, 32'h5,        32'h0,        4'd4 },
        {1'b1, 2'd0, 10'h021, 32'h2,        32'h0,        4'd4 },
        {1'b0, 2'd0, 10'h021, 32'h0,        32'h7,        4'd4 },  // R4 set accumulates
        {1'b1, 2'd0, 10'h031, 32'h4,        32'h0,        4'd4 },
        {1'b0, 2'd0, 10'h031, 32'h0,        32'h3,        4'd4 },  // R4 clear one bit
        {1'b1, 2'd1, 10'h020, 32'h00010000, 32'h0,        4'd5 },
        {1'b0, 2'd1, 10'h020, 32'h0,        32'h00010000, 4'd5 },  // R5 own copy
        {1'b0, 2'd0, 10'h030, 32'h0,        32'h0,        4'd5 },  // R5 other copy untouched
        {1'b0, 2'd2, 10'h100, 32'h0,        32'h00040004, 4'd6 },  // R6 one-hot of cpu2
        {1'b1, 2'd2, 10'h100, 32'h0000FFFF, 32'h0,        4'd6 },
        {1'b0, 2'd2, 10'h107, 32'h0,        32'h00040004, 4'd6 },  // R6 write ignored
        {1'b1, 2'd0, 10'h110, 32'h00020001, 32'h0,        4'd6 },
        {1'b0, 2'd3, 10'h110, 32'h0,        32'h00020001, 4'd6 },  // R6 shared pair
        {1'b1, 2'd0, 10'h208, 32'h44332211, 32'h0,        4'd12},
        {1'b0, 2'd1, 10'h208, 32'h0,        32'h44332211, 4'd12},  // R12 priority bytes
        {1'b1, 2'd0, 10'h000, 32'h1,        32'h0,        4'd2 },
        {1'b0, 2'd0, 10'h000, 32'h0,        32'h1,        4'd2 }   // R2 enable set
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_cpu = 2'(cpu); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int idof(input int c);
        return int'(irq_id[c*IDW +: IDW]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(2);
        check(irq_req == 0 && irq_id == 0, "R1", int'(irq_req), 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][80]) begin
                wr(int'(VEC[v][79:78]), VEC[v][77:68], VEC[v][67:36]);
            end else begin
                @(negedge clk);
                reg_cpu = VEC[v][79:78]; reg_addr = VEC[v][77:68]; reg_wr = 1'b0;
                #1;
                checks++;
                if (reg_rdata !== VEC[v][35:4]) begin
                    fails++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VEC[v][3:0], v, reg_rdata, VEC[v][35:4]);
                end
            end
        end

        // R9 level source 32 routed to cpu0 only (R6)
        spi_in[0] = 1'b1; idle(3);
        check(irq_req[0] && idof(0) == 32, "R9", idof(0), 32);
        check(!irq_req[1], "R6", int'(irq_req[1]), 0);
        wr(0, 10'h003, 32);  idle(3);
        check(irq_req[0], "R9", int'(irq_req[0]), 1);
        spi_in[0] = 1'b0; idle(3);
        check(irq_req[0] && idof(0) == 32, "R9", idof(0), 32);
        wr(0, 10'h003, 32);  idle(3);
        check(!irq_req[0], "R11", int'(irq_req[0]), 0);

        // R8 edge source 33 routed to cpu1
        wr(0, 10'h041, 32'h2);
        @(negedge clk); spi_in[1] = 1'b1;
        @(negedge clk); spi_in[1] = 1'b0;
        idle(6);
        check(irq_req[1] && idof(1) == 33, "R8", idof(1), 33);
        check(!irq_req[0], "R8", int'(irq_req[0]), 0);
        wr(1, 10'h003, 33);  idle(3);
        check(!irq_req[1], "R11", int'(irq_req[1]), 0);

        // R12 priority order and tie break, both to cpu0
        wr(0, 10'h110, 32'h00010001);
        spi_in[0] = 1'b1;
        @(negedge clk); spi_in[1] = 1'b1;
        @(negedge clk); spi_in[1] = 1'b0;
        idle(3);
        check(irq_req[0] && idof(0) == 32, "R12", idof(0), 32);
        wr(0, 10'h208, 32'h44332233); idle(3);
        check(idof(0) == 33, "R12", idof(0), 33);
        wr(0, 10'h208, 32'h44332222); idle(3);
        check(idof(0) == 32, "R12", idof(0), 32);

        // R2 global enable gates delivery
        wr(0, 10'h000, 32'h0); idle(3);
        check(irq_req == 0, "R2", int'(irq_req), 0);
        wr(0, 10'h000, 32'h1); idle(3);
        check(irq_req[0], "R2", int'(irq_req[0]), 1);
        spi_in[0] = 1'b0;
        wr(0, 10'h003, 32); wr(0, 10'h003, 33); idle(3);
        check(irq_req == 0, "R11", int'(irq_req), 0);

        // R10 SGI 5 to cpu2 only, cpu3 enabled but not targeted
        wr(2, 10'h020, 32'h20); wr(3, 10'h020, 32'h20);
        wr(0, 10'h002, 32'h00000405); idle(3);
        check(irq_req[2] && idof(2) == 5, "R10", idof(2), 5);
        check(!irq_req[3], "R10", int'(irq_req[3]), 0);
        wr(2, 10'h003, 5); idle(3);
        check(!irq_req[2], "R11", int'(irq_req[2]), 0);

        // R5 private line 16: cpu1 enabled, cpu0 not
        ppi_in[16] = 1'b1; ppi_in[0] = 1'b1; idle(3);
        check(irq_req[1] && idof(1) == 16, "R5", idof(1), 16);
        check(!irq_req[0], "R5", int'(irq_req[0]), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule